// File: doc/BRIEF.md
# Exact Long Accumulator with Tagged Command Port

This block sums a series of products without rounding. Each product arrives already split into a signed mantissa and an unsigned exponent. The block shifts the mantissa left by the exponent into a wide two's-complement fixed-point register and adds it there. Because the register is wide enough for the whole exponent range in use, the sum is exact. The block wraps only at the width of the register.

Work arrives as commands, one per cycle. Each command carries a valid flag, a 2-bit operation, an identification tag, a mantissa and an exponent. The block answers with a registered ready-for-data signal. Ready drops one cycle after a command is accepted, so the upstream side may already have launched another command in that cycle. A one-entry holding buffer catches such a command and runs it automatically once the engine is free. Every working operation keeps the engine busy for two stall cycles, so each result is committed before the next operation can read it.

A read returns the whole accumulator with the operation's tag. It also returns the bit indices of the highest and lowest set bits, which a later stage can use to normalise the value into a floating-point result.

Top module: `xacc_top`

## Requirements
- R1: An ACCUMULATE command (op code 2'b01) adds the mantissa, sign-extended as two's complement and shifted left by the unsigned exponent, to the accumulator. The sum is exact modulo 2^ACC_W.
- R2: A CLEAR command (op code 2'b10) sets the accumulator to zero. The next series of accumulations starts from zero.
- R3: A READ command (op code 2'b11) raises out_valid for exactly one cycle, in the second cycle after the cycle in which it was accepted. In that cycle out_acc holds the accumulator and out_id holds the command's tag.
- R4: With a read result, out_nz is 1 when any accumulator bit is set. out_hi is the index of the highest set bit and out_lo the index of the lowest. When the accumulator is zero, out_nz is 0 and both indices are 0.
- R5: rfd is registered. After a non-NOP command is accepted, rfd is 0 for the next two cycles. It is 1 again in the third cycle, provided the holding buffer is empty.
- R6: A NOP command (op code 2'b00) is accepted without changing the accumulator, and rfd stays 1.
- R7: A valid command presented while rfd is 0 and the holding buffer is empty is stored. It is executed automatically, in arrival order, once the stall of the current operation ends.
- R8: A valid command presented while the holding buffer is full and cannot drain in that cycle is dropped. ovf_err then rises and stays 1 until reset.
- R9: After reset, rfd is 1, out_valid is 0, ovf_err is 0 and the accumulator reads as zero.
- R10: A READ that waited in the holding buffer returns an accumulator that includes every command accepted before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command valid |
| in_op | input | 2 | Operation: 00 NOP, 01 ACCUMULATE, 10 CLEAR, 11 READ |
| in_id | input | ID_W | Command tag |
| in_mant | input | MANT_W | Signed mantissa |
| in_exp | input | EXP_W | Unsigned left-shift amount |
| rfd | output | 1 | Ready for a command |
| out_valid | output | 1 | One-cycle strobe for a read result |
| out_id | output | ID_W | Tag of the read command |
| out_acc | output | ACC_W | Accumulator value |
| out_hi | output | IDX_W | Index of the highest set bit |
| out_lo | output | IDX_W | Index of the lowest set bit |
| out_nz | output | 1 | Accumulator is nonzero |
| ovf_err | output | 1 | Sticky flag: a command was dropped |

## Verification
A wrong accumulator word stays hidden until the next READ. That read shows it in out_acc and in the span indices two cycles after it is accepted. This is why each sweep step ends with a read. A wrong stall count or holding-buffer state shows at rfd within a cycle or two. It also surfaces later as a lost or reordered command, seen as a wrong sum or tag in a following read. A buffer that fails to fill or drain shows either as a missing result strobe or as ovf_err rising when it should not.

// File: rtl/xacc_pkg.sv
package xacc_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_ACC = 2'b01,
    OP_CLR = 2'b10,
    OP_RD  = 2'b11
  } xacc_op_e;
endpackage

// File: rtl/xacc_issue.sv
// Command intake: one-entry holding buffer, stall counter, registered ready.
module xacc_issue
  import xacc_pkg::*;
#(
  parameter int CMD_W = 16,
  parameter int STALL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [CMD_W-1:0] in_cmd,
  output logic             iss_valid,
  output logic [CMD_W-1:0] iss_cmd,
  output logic             rdy,
  output logic             ovf
);
  localparam int CNT_W = (STALL < 1) ? 1 : $clog2(STALL + 1);

  logic [CNT_W-1:0] cnt, cnt_n;
  logic             hb_full, hb_full_n;
  logic [CMD_W-1:0] hb_cmd;
  logic             eng_free, take_hb, take_in, store, drop, busy_op;

  always_comb begin
    eng_free  = (cnt == '0);
    take_hb   = eng_free && hb_full;
    take_in   = eng_free && !hb_full && in_valid;
    iss_valid = take_hb || take_in;
    iss_cmd   = hb_full ? hb_cmd : in_cmd;
    store     = in_valid && !take_in && (!hb_full || take_hb);
    drop      = in_valid && !take_in && hb_full && !take_hb;
    busy_op   = iss_valid && (xacc_op_e'(iss_cmd[CMD_W-1 -: 2]) != OP_NOP);
    if (store)        hb_full_n = 1'b1;
    else if (take_hb) hb_full_n = 1'b0;
    else              hb_full_n = hb_full;
    if (busy_op)       cnt_n = CNT_W'(STALL);
    else if (eng_free) cnt_n = '0;
    else               cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      hb_full <= 1'b0;
      rdy     <= 1'b1;
      ovf     <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      hb_full <= hb_full_n;
      rdy     <= (cnt_n == '0) && !hb_full_n;
      ovf     <= ovf || drop;
    end
  end

  always_ff @(posedge clk) begin
    if (store) hb_cmd <= in_cmd;
  end
endmodule

// File: rtl/xacc_align.sv
// Places a signed mantissa at its binary weight inside the wide register.
module xacc_align #(
  parameter int MANT_W = 53,
  parameter int EXP_W  = 11,
  parameter int ACC_W  = 256
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  sh,
  output logic [ACC_W-1:0]  addend
);
  logic [ACC_W-1:0] ext;

  generate
    if (ACC_W > MANT_W) begin : g_wide
      assign ext = {{(ACC_W-MANT_W){mant[MANT_W-1]}}, mant};
    end else begin : g_narrow
      assign ext = mant[ACC_W-1:0];
    end
  endgenerate

  assign addend = ext << sh;
endmodule

// File: rtl/xacc_span.sv
// Finds the highest and lowest set bit of the accumulator.
module xacc_span #(
  parameter int W     = 256,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] hi,
  output logic [IDX_W-1:0] lo,
  output logic             nz
);
  always_comb begin
    hi = '0;
    lo = '0;
    nz = |vec;
    for (int i = 0; i < W; i++)
      if (vec[i]) hi = IDX_W'(i);
    for (int i = W - 1; i >= 0; i--)
      if (vec[i]) lo = IDX_W'(i);
  end
endmodule

// File: rtl/xacc_top.sv
module xacc_top
  import xacc_pkg::*;
#(
  parameter int MANT_W = 53,
  parameter int EXP_W  = 11,
  parameter int ACC_W  = 256,
  parameter int ID_W   = 8,
  parameter int STALL  = 2,
  localparam int IDX_W = $clog2(ACC_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [ID_W-1:0]   in_id,
  input  logic [MANT_W-1:0] in_mant,
  input  logic [EXP_W-1:0]  in_exp,
  output logic              rfd,
  output logic              out_valid,
  output logic [ID_W-1:0]   out_id,
  output logic [ACC_W-1:0]  out_acc,
  output logic [IDX_W-1:0]  out_hi,
  output logic [IDX_W-1:0]  out_lo,
  output logic              out_nz,
  output logic              ovf_err
);
  localparam int CMD_W  = 2 + ID_W + MANT_W + EXP_W;
  localparam int ID_LSB = MANT_W + EXP_W;

  logic             iss_valid;
  logic [CMD_W-1:0] iss_cmd;
  xacc_op_e         iss_op;
  logic [ACC_W-1:0] addend;

  xacc_issue #(.CMD_W(CMD_W), .STALL(STALL)) i_issue (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_cmd   ({in_op, in_id, in_mant, in_exp}),
    .iss_valid(iss_valid),
    .iss_cmd  (iss_cmd),
    .rdy      (rfd),
    .ovf      (ovf_err)
  );

  assign iss_op = xacc_op_e'(iss_cmd[CMD_W-1 -: 2]);

  xacc_align #(.MANT_W(MANT_W), .EXP_W(EXP_W), .ACC_W(ACC_W)) i_align (
    .mant  (iss_cmd[EXP_W +: MANT_W]),
    .sh    (iss_cmd[EXP_W-1:0]),
    .addend(addend)
  );

  // Stage 1: issued command with its aligned addend.
  logic             s1_vld;
  xacc_op_e         s1_op;
  logic [ID_W-1:0]  s1_id;
  logic [ACC_W-1:0] s1_add;

  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= iss_valid && (iss_op != OP_NOP);
    s1_op  <= iss_op;
    s1_id  <= iss_cmd[ID_LSB +: ID_W];
    s1_add <= addend;
  end

  // Stage 2: accumulator update or read capture.
  logic [ACC_W-1:0] acc;
  logic [IDX_W-1:0] sp_hi, sp_lo;
  logic             sp_nz;

  xacc_span #(.W(ACC_W), .IDX_W(IDX_W)) i_span (
    .vec(acc),
    .hi (sp_hi),
    .lo (sp_lo),
    .nz (sp_nz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (s1_vld) begin
      case (s1_op)
        OP_ACC:  acc <= acc + s1_add;
        OP_CLR:  acc <= '0;
        default: acc <= acc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_vld && (s1_op == OP_RD);
    if (s1_vld && (s1_op == OP_RD)) begin
      out_acc <= acc;
      out_id  <= s1_id;
      out_hi  <= sp_hi;
      out_lo  <= sp_lo;
      out_nz  <= sp_nz;
    end
  end
endmodule

// File: rtl/xacc_chk.sv
module xacc_chk #(
  parameter int ACC_W = 256,
  parameter int IDX_W = $clog2(ACC_W)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       in_op,
  input logic             rfd,
  input logic             out_valid,
  input logic [ACC_W-1:0] out_acc,
  input logic [IDX_W-1:0] out_hi,
  input logic [IDX_W-1:0] out_lo,
  input logic             out_nz,
  input logic             ovf_err
);
  // R5
  rdy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rfd && in_op != 2'b00) |=> !rfd);
  // R5
  rdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rfd && in_op != 2'b00) |=> ##1 !rfd);
  // R6
  nop_keeps_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rfd && in_op == 2'b00) |=> rfd);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);
  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R4
  span_order_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_nz) |-> (out_hi >= out_lo && out_acc[out_hi] && out_acc[out_lo]));
  // R4
  span_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_nz) |-> (out_acc == '0 && out_hi == '0 && out_lo == '0));
endmodule

bind xacc_top xacc_chk #(.ACC_W(ACC_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_op    (in_op),
  .rfd      (rfd),
  .out_valid(out_valid),
  .out_acc  (out_acc),
  .out_hi   (out_hi),
  .out_lo   (out_lo),
  .out_nz   (out_nz),
  .ovf_err  (ovf_err)
);

// File: tb/test_xacc_top.sv
`timescale 1ns/1ps
module test_xacc_top;
  localparam int MW = 4, EW = 3, AW = 16, IW = 4, XW = 4;
  localparam logic [1:0] NOP = 2'b00, ACC = 2'b01, CLR = 2'b10, RD = 2'b11;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_op = '0;
  logic [IW-1:0] in_id = '0;
  logic [MW-1:0] in_mant = '0;
  logic [EW-1:0] in_exp = '0;
  logic rfd, out_valid, out_nz, ovf_err;
  logic [IW-1:0] out_id;
  logic [AW-1:0] out_acc;
  logic [XW-1:0] out_hi, out_lo;

  always #2.5 clk = ~clk;

  xacc_top #(.MANT_W(MW), .EXP_W(EW), .ACC_W(AW), .ID_W(IW), .STALL(2)) i_xacc_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_id(in_id),
    .in_mant(in_mant), .in_exp(in_exp), .rfd(rfd), .out_valid(out_valid),
    .out_id(out_id), .out_acc(out_acc), .out_hi(out_hi), .out_lo(out_lo),
    .out_nz(out_nz), .ovf_err(ovf_err)
  );

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] model;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] term(input logic [MW-1:0] m, input logic [EW-1:0] e);
    logic [AW-1:0] t;
    t = {{(AW-MW){m[MW-1]}}, m};
    return t << e;
  endfunction

  function automatic logic [XW-1:0] top_bit(input logic [AW-1:0] v);
    logic [XW-1:0] r = '0;
    for (int i = 0; i < AW; i++) if (v[i]) r = XW'(i);
    return r;
  endfunction

  function automatic logic [XW-1:0] low_bit(input logic [AW-1:0] v);
    logic [XW-1:0] r = '0;
    for (int i = AW - 1; i >= 0; i--) if (v[i]) r = XW'(i);
    return r;
  endfunction

  task automatic drive(input logic [1:0] op, input logic [IW-1:0] id,
                       input logic [MW-1:0] m, input logic [EW-1:0] e);
    in_valid = 1'b1; in_op = op; in_id = id; in_mant = m; in_exp = e;
  endtask

  // Waits for rfd, presents one command for one cycle, returns at the next negedge.
  task automatic send(input logic [1:0] op, input logic [IW-1:0] id,
                      input logic [MW-1:0] m, input logic [EW-1:0] e);
    @(negedge clk);
    while (!rfd) @(negedge clk);
    drive(op, id, m, e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_result(input string req, input logic [IW-1:0] id);
    chk(req, "out_valid", 32'(out_valid), 32'd1);
    chk(req, "out_acc", 32'(out_acc), 32'(model));
    chk(req, "out_id", 32'(out_id), 32'(id));
    chk("R4", "out_nz", 32'(out_nz), 32'(|model));
    chk("R4", "out_hi", 32'(out_hi), 32'(top_bit(model)));
    chk("R4", "out_lo", 32'(out_lo), 32'(low_bit(model)));
  endtask

  // R3: result appears in the second cycle after acceptance, for one cycle only.
  task automatic read_check(input string req, input logic [IW-1:0] id);
    send(RD, id, '0, '0);
    chk("R3", "out_valid one cycle after accept", 32'(out_valid), 32'd0);
    @(negedge clk);
    check_result(req, id);
    @(negedge clk);
    chk("R3", "out_valid strobe width", 32'(out_valid), 32'd0);
  endtask

  task automatic do_reset;
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "rfd in reset", 32'(rfd), 32'd1);
    chk("R9", "out_valid in reset", 32'(out_valid), 32'd0);
    chk("R9", "ovf_err in reset", 32'(ovf_err), 32'd0);
    rst = 1'b0;
    model = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    read_check("R9", 4'd1);

    // R6: NOP accepted, ready stays high, accumulator unchanged
    send(NOP, 4'd2, 4'd5, 3'd3);
    chk("R6", "rfd after NOP", 32'(rfd), 32'd1);
    read_check("R6", 4'd3);

    // R5: ready falls after acceptance and returns after two stall cycles
    @(negedge clk);
    while (!rfd) @(negedge clk);
    drive(ACC, 4'd4, 4'd3, 3'd2);
    @(negedge clk); in_valid = 1'b0;
    chk("R5", "rfd cycle 1 after accept", 32'(rfd), 32'd0);
    @(negedge clk);
    chk("R5", "rfd cycle 2 after accept", 32'(rfd), 32'd0);
    @(negedge clk);
    chk("R5", "rfd cycle 3 after accept", 32'(rfd), 32'd1);
    model = model + term(4'd3, 3'd2);
    read_check("R1", 4'd5);

    // R1 R2: exhaustive single-term sweep, each starting from CLEAR
    for (int m = 0; m < 16; m++) begin
      for (int e = 0; e < 8; e++) begin
        send(CLR, 4'(m), '0, '0);
        model = '0;
        send(ACC, 4'(e), 4'(m), 3'(e));
        model = term(4'(m), 3'(e));
        read_check("R1 R2", 4'(m + e));
      end
    end

    // R1: running sum over every mantissa and exponent
    send(CLR, 4'd0, '0, '0);
    model = '0;
    for (int e = 0; e < 8; e++) begin
      for (int m = 0; m < 16; m++) begin
        send(ACC, 4'(m), 4'(m), 3'(e));
        model = model + term(4'(m), 3'(e));
      end
      read_check("R1", 4'(e));
    end

    // R1: wrap modulo 2^ACC_W
    send(CLR, 4'd0, '0, '0);
    model = '0;
    for (int k = 0; k < 80; k++) begin
      send(ACC, 4'd1, 4'd7, 3'd7);
      model = model + term(4'd7, 3'd7);
    end
    read_check("R1", 4'd10);

    // R7 R8: second command buffered, third dropped
    send(CLR, 4'd0, '0, '0);
    model = '0;
    @(negedge clk);
    while (!rfd) @(negedge clk);
    drive(ACC, 4'd5, 4'd5, 3'd1);
    @(negedge clk);
    drive(ACC, 4'd6, 4'hD, 3'd3);
    @(negedge clk);
    chk("R8", "ovf_err before drop", 32'(ovf_err), 32'd0);
    drive(ACC, 4'd7, 4'd7, 3'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "ovf_err after drop", 32'(ovf_err), 32'd1);
    model = term(4'd5, 3'd1) + term(4'hD, 3'd3);
    read_check("R7", 4'd8);

    // R10: READ held in the buffer sees the preceding accumulate
    @(negedge clk);
    while (!rfd) @(negedge clk);
    drive(ACC, 4'd1, 4'd1, 3'd4);
    @(negedge clk);
    drive(RD, 4'd9, '0, '0);
    @(negedge clk);
    in_valid = 1'b0;
    model = model + term(4'd1, 3'd4);
    for (int w = 0; w < 10 && !out_valid; w++) @(negedge clk);
    check_result("R10", 4'd9);
    chk("R8", "ovf_err sticky", 32'(ovf_err), 32'd1);

    // R9: reset clears the sticky flag and the accumulator
    @(negedge clk);
    do_reset();
    @(negedge clk);
    chk("R9", "ovf_err after reset", 32'(ovf_err), 32'd0);
    read_check("R9", 4'd11);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule